// File: doc/BRIEF.md
# Command-Driven SPI Word Engine

This block is the shifting core of a half-duplex SPI master. Software writes a command word through a small register port. The command selects a chip select, a word length of 1 to 128 bits, a frame length in words, and an operation. The engine then moves exactly one word, either out on one data line or in on one, two or four lines. When the word is done it drops BUSY and raises a word-complete flag. Outgoing data comes from four 32-bit holding registers and incoming data lands in the same registers. The serial clock runs at half the system clock, one beat taking two cycles.

Chip select is held across consecutive commands until the frame's programmed word count is reached, or until an invalidate command ends the frame early. A device-control register gives each chip select its own 8-bit lane holding clock polarity, clock phase and chip-select polarity. The idle clock level follows the chip select named by the most recent accepted command, so an invalidate aimed at a device also parks the clock at that device's idle level.

Top module: `spi_word_engine`

## Requirements
- R1: After reset, status reads 0 (BUSY bit 0 and word-complete bit 1 both clear), all holding registers read 0, every chip-select pin sits at its inactive level (high, since all polarities reset to 0), the serial clock is 0 and no data line is driven.
- R2: A command is a write to address 0 holding the chip-select index in bits 29:28, the word length minus one in bits 25:19, the operation in bits 18:16 and the frame length in words minus one in bits 11:0. An accepted transfer command sets BUSY and clears word-complete on the next cycle.
- R3: Operation 2 writes a word MSB first on data line 0, the only line with its output enable set. The word is the low N bits of {reg3, reg2, reg1, reg0}, where holding register k sits at address 4+k; for 128 bits reg3's MSB leaves first.
- R4: Operation 1 reads one bit per beat from data line 1. Operations 5 and 6 are the 3-pin forms of operations 1 and 2: the read samples data line 0 instead of line 1.
- R5: Operation 3 reads two bits per beat with line 1 carrying the higher bit; operation 7 reads four bits per beat with line 3 carrying the highest. A word of N bits takes N, N/2 or N/4 clock beats; N is a multiple of the lane count.
- R6: A read stores the received word in the low N bits of {reg3..reg0} with all higher bits zero, in the same cycle that word-complete rises.
- R7: BUSY falls and word-complete rises exactly 2 x beats cycles after the cycle in which BUSY is first seen high. The clock idles at the lane's polarity. With phase 0 data is sampled on the first edge of each beat, and with phase 1 on the second.
- R8: Chip select stays asserted between the words of one frame and is released as the last word of the frame completes.
- R9: Operation 4 (invalidate) ends the frame at once without any clock beat, clears word-complete and selects the named chip select's lane for the idle clock level.
- R10: While BUSY is set, writes to the command and holding registers are ignored. Operation 0 is ignored at any time.
- R11: Device control (address 1) has an 8-bit lane for chip select n at bits 8n+7:8n: bit 0 clock polarity, bit 1 chip-select polarity (1 = active high), bit 2 clock phase, bits 7:3 stored and read back but with no effect on timing. Only the selected chip select is ever active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address (0 command, 1 device control, 2 status, 4..7 holding registers) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| sclk | output | 1 | Serial clock |
| csPin | output | 4 | Chip-select pins, polarity per lane |
| sdOut | output | 4 | Serial data out, line 0 used |
| sdOe | output | 4 | Output enables for the data lines |
| sdIn | input | 4 | Serial data in |

## Verification
The hardest state to reach from the ports is a frame that is still open between commands, where chip select must stay asserted while the engine is idle and a new command must reuse the held chip select rather than the one in its own fields. The stimulus opens multi-word frames and checks the pin between words. It closes one frame by count and another by invalidate in mid-frame. A bench slave reacts only to the serial clock, in every polarity and phase, and drives wrong-line decoys so that a read sampling the wrong line is visible in the stored word.

// File: rtl/spiw_pkg.sv
package spiw_pkg;

  typedef enum logic [1:0] {
    LINES_MISO   = 2'd0,
    LINES_SHARED = 2'd1,
    LINES_DUAL   = 2'd2,
    LINES_QUAD   = 2'd3
  } rxLines_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     isRead;
    rxLines_e lines;
    logic     step;
    logic     last;
  } dpCtl_t;

  localparam logic [2:0] OP_NONE   = 3'd0;
  localparam logic [2:0] OP_RD1    = 3'd1;
  localparam logic [2:0] OP_WR1    = 3'd2;
  localparam logic [2:0] OP_RD2    = 3'd3;
  localparam logic [2:0] OP_INV    = 3'd4;
  localparam logic [2:0] OP_RD1_3P = 3'd5;
  localparam logic [2:0] OP_WR1_3P = 3'd6;
  localparam logic [2:0] OP_RD4    = 3'd7;

endpackage

// File: rtl/spiw_datapath.sv
module spiw_datapath
  import spiw_pkg::*;
#(
  parameter int MAXW = 128,
  localparam int NREG = MAXW / 32,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int WLW  = $clog2(MAXW)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            dataWe,
  input  logic [IDXW-1:0] dataIdx,
  input  logic [31:0]     dataWdata,
  output logic [31:0]     dataRdata,
  input  dpCtl_t          ctl,
  input  logic [WLW-1:0]  wlenM1,
  input  logic [3:0]      sdIn,
  output logic            txBit
);

  logic [31:0]     dataReg [NREG];
  logic [MAXW-1:0] holdFlat;
  logic [MAXW-1:0] alignedTx;
  logic [MAXW-1:0] shiftReg;
  logic [MAXW-1:0] shiftNext;
  logic            captureNow;

  assign captureNow = ctl.step && ctl.last && ctl.isRead;

  for (genvar k = 0; k < NREG; k++) begin : g_hold
    assign holdFlat[32*k +: 32] = dataReg[k];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataReg[k] <= '0;
      end else if (captureNow) begin
        dataReg[k] <= shiftNext[32*k +: 32];
      end else if (dataWe && dataIdx == IDXW'(k)) begin
        dataReg[k] <= dataWdata;
      end
    end
  end

  assign dataRdata = dataReg[dataIdx];

  // Move the word's MSB to the top of the shifter
  always_comb alignedTx = holdFlat << (MAXW - 1 - int'(wlenM1));

  always_comb begin
    shiftNext = {shiftReg[MAXW-2:0], 1'b0};
    if (ctl.isRead) begin
      unique case (ctl.lines)
        LINES_MISO:   shiftNext = {shiftReg[MAXW-2:0], sdIn[1]};
        LINES_SHARED: shiftNext = {shiftReg[MAXW-2:0], sdIn[0]};
        LINES_DUAL:   shiftNext = {shiftReg[MAXW-3:0], sdIn[1:0]};
        LINES_QUAD:   shiftNext = {shiftReg[MAXW-5:0], sdIn[3:0]};
        default:      shiftNext = {shiftReg[MAXW-2:0], sdIn[1]};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctl.load) begin
      shiftReg <= ctl.isRead ? '0 : alignedTx;
    end else if (ctl.step) begin
      shiftReg <= shiftNext;
    end
  end

  assign txBit = shiftReg[MAXW-1];

  // R10: holding registers do not move between beats of a word
  a_r10_hold_stable_midword: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.last) |=> $stable(holdFlat));

  // R6: a load never coincides with a capture
  a_r6_no_load_on_capture: assert property (@(posedge clk) disable iff (!rstN)
    captureNow |-> !ctl.load);

endmodule

// File: rtl/spiw_ctrl.sv
module spiw_ctrl
  import spiw_pkg::*;
#(
  parameter int NCS      = 4,
  parameter int MAXW     = 128,
  parameter int MAXFRAME = 4096,
  localparam int CSW = $clog2(NCS),
  localparam int WLW = $clog2(MAXW),
  localparam int FLW = $clog2(MAXFRAME),
  localparam int DCW = 8 * NCS
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmdWe,
  input  logic [CSW-1:0] cmdCs,
  input  logic [WLW-1:0] cmdWlenM1,
  input  logic [2:0]     cmdOp,
  input  logic [FLW-1:0] cmdFrame,
  input  logic           dcWe,
  input  logic [DCW-1:0] dcWord,
  output logic [DCW-1:0] dcReg,
  output logic           busy,
  output logic           wcFlag,
  output dpCtl_t         ctl,
  output logic [NCS-1:0] csPin,
  output logic           sclk,
  output logic           txOe
);

  localparam logic [WLW:0] BEAT_ONE  = 1;
  localparam logic [FLW-1:0] FRM_ONE = 1;

  logic           frameActive;
  logic           ph;
  logic [CSW-1:0] csSel;
  logic [FLW-1:0] frameLast;
  logic [FLW-1:0] frameCnt;
  logic [WLW:0]   beatCnt;
  logic [WLW:0]   beatLast;
  logic           opRead;
  rxLines_e       opLines;

  logic           accept;
  logic           isXfer;
  logic           isInv;
  logic           cmdRead;
  rxLines_e       cmdLines;
  logic [1:0]     laneShift;
  logic [WLW:0]   wlenFull;
  logic [WLW:0]   beatLastNext;
  logic           laneCpol;
  logic           laneCpha;
  logic           wordEnd;
  logic [NCS-1:0] csActive;

  // Command decode
  always_comb begin
    cmdRead  = 1'b0;
    cmdLines = LINES_MISO;
    isXfer   = 1'b0;
    unique case (cmdOp)
      OP_RD1:    begin cmdRead = 1'b1; cmdLines = LINES_MISO;   isXfer = 1'b1; end
      OP_RD1_3P: begin cmdRead = 1'b1; cmdLines = LINES_SHARED; isXfer = 1'b1; end
      OP_RD2:    begin cmdRead = 1'b1; cmdLines = LINES_DUAL;   isXfer = 1'b1; end
      OP_RD4:    begin cmdRead = 1'b1; cmdLines = LINES_QUAD;   isXfer = 1'b1; end
      OP_WR1, OP_WR1_3P: isXfer = 1'b1;
      default: ;
    endcase
  end

  assign accept = cmdWe && !busy;
  assign isInv  = accept && (cmdOp == OP_INV);

  always_comb begin
    unique case (cmdLines)
      LINES_DUAL: laneShift = 2'd1;
      LINES_QUAD: laneShift = 2'd2;
      default:    laneShift = 2'd0;
    endcase
  end

  assign wlenFull     = {1'b0, cmdWlenM1} + BEAT_ONE;
  assign beatLastNext = (wlenFull >> laneShift) - BEAT_ONE;
  assign wordEnd      = busy && ph && (beatCnt == beatLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dcReg <= '0;
    end else if (dcWe) begin
      dcReg <= dcWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      wcFlag      <= 1'b0;
      frameActive <= 1'b0;
      ph          <= 1'b0;
      csSel       <= '0;
      frameLast   <= '0;
      frameCnt    <= '0;
      beatCnt     <= '0;
      beatLast    <= '0;
      opRead      <= 1'b0;
      opLines     <= LINES_MISO;
    end else if (accept && isXfer) begin
      busy     <= 1'b1;
      wcFlag   <= 1'b0;
      ph       <= 1'b0;
      beatCnt  <= '0;
      beatLast <= beatLastNext;
      opRead   <= cmdRead;
      opLines  <= cmdLines;
      if (!frameActive) begin
        frameActive <= 1'b1;
        csSel       <= cmdCs;
        frameLast   <= cmdFrame;
        frameCnt    <= '0;
      end
    end else if (isInv) begin
      wcFlag      <= 1'b0;
      frameActive <= 1'b0;
      frameCnt    <= '0;
      csSel       <= cmdCs;
    end else if (busy) begin
      ph <= ~ph;
      if (wordEnd) begin
        busy   <= 1'b0;
        wcFlag <= 1'b1;
        if (frameCnt == frameLast) begin
          frameActive <= 1'b0;
          frameCnt    <= '0;
        end else begin
          frameCnt <= frameCnt + FRM_ONE;
        end
      end else if (ph) begin
        beatCnt <= beatCnt + BEAT_ONE;
      end
    end
  end

  // Per-lane mode bits of the selected chip select
  assign laneCpol = dcReg[{csSel, 3'd0}];
  assign laneCpha = dcReg[{csSel, 3'd2}];
  assign sclk     = busy ? (laneCpol ^ ph ^ laneCpha) : laneCpol;
  assign txOe     = busy && !opRead;

  for (genvar n = 0; n < NCS; n++) begin : g_cs
    assign csActive[n] = frameActive && (csSel == CSW'(n));
    assign csPin[n]    = dcReg[8*n+1] ? csActive[n] : ~csActive[n];
  end

  always_comb begin
    ctl.load   = accept && isXfer;
    ctl.isRead = (accept && isXfer) ? cmdRead : opRead;
    ctl.lines  = (accept && isXfer) ? cmdLines : opLines;
    ctl.step   = busy && ph;
    ctl.last   = beatCnt == beatLast;
  end

  // R8: shifting only happens inside an open frame
  a_r8_busy_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> frameActive);

  // R2: an accepted command raises BUSY and drops word-complete
  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isXfer) |=> (busy && !wcFlag));

  // R7: BUSY never falls without word-complete
  a_r7_done_sets_wc: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> wcFlag);

  // R9: invalidate closes the frame on the next cycle
  a_r9_inv_closes: assert property (@(posedge clk) disable iff (!rstN)
    isInv |=> (!frameActive && !busy));

  // R10: a command written while busy leaves frame settings alone
  a_r10_busy_cmd_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWe) |=> ($stable(csSel) && $stable(frameLast)));

  // R11: at most one chip select is active
  a_r11_one_cs: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csActive));

endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
  import spiw_pkg::*;
#(
  parameter int NCS      = 4,
  parameter int MAXW     = 128,
  parameter int MAXFRAME = 4096
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           regWe,
  input  logic [2:0]     regAddr,
  input  logic [31:0]    regWdata,
  output logic [31:0]    regRdata,
  output logic           sclk,
  output logic [NCS-1:0] csPin,
  output logic [3:0]     sdOut,
  output logic [3:0]     sdOe,
  input  logic [3:0]     sdIn
);

  localparam int CSW  = $clog2(NCS);
  localparam int WLW  = $clog2(MAXW);
  localparam int FLW  = $clog2(MAXFRAME);
  localparam int DCW  = 8 * NCS;
  localparam int NREG = MAXW / 32;
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;

  localparam logic [2:0] ADDR_CMD  = 3'd0;
  localparam logic [2:0] ADDR_DC   = 3'd1;
  localparam logic [2:0] ADDR_STAT = 3'd2;

  dpCtl_t         dpCtl;
  logic [DCW-1:0] dcReg;
  logic           busy;
  logic           wcFlag;
  logic           txBit;
  logic           txOe;
  logic [31:0]    dataRdata;
  logic           cmdWe;
  logic           dcWe;
  logic           dataWe;

  assign cmdWe  = regWe && (regAddr == ADDR_CMD);
  assign dcWe   = regWe && (regAddr == ADDR_DC);
  assign dataWe = regWe && regAddr[2] && !busy;

  spiw_ctrl #(.NCS(NCS), .MAXW(MAXW), .MAXFRAME(MAXFRAME)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdWe     (cmdWe),
    .cmdCs     (regWdata[28 +: CSW]),
    .cmdWlenM1 (regWdata[19 +: WLW]),
    .cmdOp     (regWdata[18:16]),
    .cmdFrame  (regWdata[0 +: FLW]),
    .dcWe      (dcWe),
    .dcWord    (regWdata[DCW-1:0]),
    .dcReg     (dcReg),
    .busy      (busy),
    .wcFlag    (wcFlag),
    .ctl       (dpCtl),
    .csPin     (csPin),
    .sclk      (sclk),
    .txOe      (txOe)
  );

  spiw_datapath #(.MAXW(MAXW)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dataWe    (dataWe),
    .dataIdx   (regAddr[IDXW-1:0]),
    .dataWdata (regWdata),
    .dataRdata (dataRdata),
    .ctl       (dpCtl),
    .wlenM1    (regWdata[19 +: WLW]),
    .sdIn      (sdIn),
    .txBit     (txBit)
  );

  always_comb begin
    regRdata = '0;
    if (regAddr[2]) regRdata = dataRdata;
    else if (regAddr == ADDR_DC) regRdata = 32'(dcReg);
    else if (regAddr == ADDR_STAT) regRdata = {30'd0, wcFlag, busy};
  end

  assign sdOut = {3'b000, txBit};
  assign sdOe  = {3'b000, txOe};

endmodule

// File: tb/test_spi_word_engine.sv
`timescale 1ns/1ps
module test_spi_word_engine;

  function automatic logic [31:0] cmdOf(int cs, int wl, int op, int fr);
    return (32'(cs) << 28) | (32'(wl - 1) << 19) | (32'(op) << 16) | 32'(fr - 1);
  endfunction

  // {command, device control, word}
  localparam int NV = 7;
  localparam logic [191:0] VEC [NV] = '{
    {cmdOf(0,   8, 2, 1), 32'h0000_0000, 128'hA5},
    {cmdOf(1,  32, 6, 1), 32'h0000_0500, 128'h1234_5678},
    {cmdOf(0, 128, 2, 1), 32'h0000_0004, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210},
    {cmdOf(2,  16, 1, 1), 32'h0002_0000, 128'hBEEF},
    {cmdOf(3,  32, 3, 1), 32'h0100_0000, 128'hC3A5_0F96},
    {cmdOf(0, 128, 7, 1), 32'h0000_0005, 128'h9E37_79B9_7F4A_7C15_F39C_C060_5CED_C834},
    {cmdOf(1,   8, 5, 1), 32'h0000_0000, 128'h6D}
  };

  logic        clk = 0;
  logic        rstN = 0;
  logic        regWe = 0;
  logic [2:0]  regAddr = 0;
  logic [31:0] regWdata = 0;
  logic [31:0] regRdata;
  logic        sclk;
  logic [3:0]  csPin;
  logic [3:0]  sdOut;
  logic [3:0]  sdOe;
  logic [3:0]  sdIn = 0;

  int checks = 0;
  int errors = 0;

  // bench slave state
  logic         tbCpol = 0, tbCpha = 0, tbCsPol = 0;
  int           tbCs = 0;
  int           slvWl = 8, slvLanes = 1, slvMode = 0;
  logic [127:0] slvWord = 0;
  logic [127:0] txCap = 0;
  int           edges = 0, rxBeat = 0, csBad = 0;

  always #10 clk = ~clk;

  spi_word_engine i_spi_word_engine (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sclk(sclk), .csPin(csPin),
    .sdOut(sdOut), .sdOe(sdOe), .sdIn(sdIn)
  );

  function automatic logic [3:0] slvDrive(int beat);
    logic [3:0] chunk;
    int sh;
    if (beat < 0 || beat >= slvWl / slvLanes) return 4'd0;
    sh = slvWl - (beat + 1) * slvLanes;
    chunk = 4'((slvWord >> sh) & 128'hF);
    case (slvMode)
      0: return {2'b00, chunk[0], ~chunk[0]};
      1: return {2'b00, ~chunk[0], chunk[0]};
      2: return {2'b00, chunk[1:0]};
      default: return chunk;
    endcase
  endfunction

  always @(sclk) begin
    if (sclk == (tbCpol ^ ~tbCpha)) begin
      edges++;
      txCap = {txCap[126:0], sdOut[0]};
      if (csPin[tbCs] != tbCsPol) csBad++;
    end else begin
      rxBeat++;
      sdIn <= slvDrive(rxBeat);
    end
  end

  function automatic logic [127:0] maskOf(int wl);
    return (wl >= 128) ? '1 : ((128'd1 << wl) - 128'd1);
  endfunction

  task automatic chk(input logic ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  task automatic waitIdle(output int cyc);
    regAddr = 3'd2;
    #1;
    cyc = 0;
    while (regRdata[0] && cyc < 1000) begin
      @(negedge clk);
      #1;
      cyc++;
    end
  endtask

  task automatic armSlave(input int cs, input logic [31:0] dc, input int op,
                          input int wl, input logic [127:0] w);
    tbCs = cs;
    tbCpol = dc[8*cs]; tbCsPol = dc[8*cs+1]; tbCpha = dc[8*cs+2];
    slvLanes = (op == 3) ? 2 : (op == 7) ? 4 : 1;
    slvMode = (op == 1) ? 0 : (op == 5) ? 1 : (op == 3) ? 2 : 3;
    slvWl = wl; slvWord = w;
    txCap = 0; edges = 0; csBad = 0;
    rxBeat = tbCpha ? -1 : 0;
    sdIn = slvDrive(rxBeat);
  endtask

  function automatic logic [3:0] idleCs(input logic [31:0] dc);
    logic [3:0] r;
    for (int n = 0; n < 4; n++) r[n] = dc[8*n+1] ? 1'b0 : 1'b1;
    return r;
  endfunction

  logic done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [127:0] pat;
    int cyc;

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    regRead(3'd2, v);
    chk(v == 0, "R1 status", v, 0);
    regRead(3'd4, v);
    chk(v == 0, "R1 data0", v, 0);
    chk(csPin == 4'hF, "R1 cs idle", csPin, 4'hF);
    chk(sclk == 1'b0 && sdOe == 4'h0, "R1 sclk/oe", {sclk, sdOe}, 0);

    // Vector walk: R3 R4 R5 R6 R7 R11
    for (int i = 0; i < NV; i++) begin
      logic [31:0] cmd, dc;
      logic [127:0] w, m;
      int cs, wl, op, lanes;
      logic isRd;
      cmd = VEC[i][191:160]; dc = VEC[i][159:128]; w = VEC[i][127:0];
      cs = int'(cmd[29:28]); wl = int'(cmd[25:19]) + 1; op = int'(cmd[18:16]);
      lanes = (op == 3) ? 2 : (op == 7) ? 4 : 1;
      isRd = (op == 1) || (op == 3) || (op == 5) || (op == 7);
      m = maskOf(wl);
      regWrite(3'd1, dc);
      regWrite(3'd0, cmdOf(cs, 8, 4, 1));
      for (int k = 0; k < 4; k++)
        regWrite(3'(4 + k), isRd ? 32'hFFFF_FFFF : w[32*k +: 32]);
      armSlave(cs, dc, op, wl, w);
      regWrite(3'd0, cmd);
      waitIdle(cyc);
      chk(cyc == 2 * wl / lanes, "R7 busy cycles", 128'(cyc), 128'(2 * wl / lanes));
      chk(edges == wl / lanes, "R5 clock beats", 128'(edges), 128'(wl / lanes));
      chk(csBad == 0, "R11 cs active during word", 128'(csBad), 0);
      regRead(3'd2, v);
      chk(v == 32'd2, "R7 word-complete", v, 2);
      chk(csPin == idleCs(dc), "R8 cs released after frame", csPin, idleCs(dc));
      if (isRd) begin
        pat = 0;
        for (int k = 0; k < 4; k++) begin
          regRead(3'(4 + k), v);
          pat[32*k +: 32] = v;
        end
        chk(pat == (w & m), (op == 1) ? "R4 single read" : (op == 5) ? "R4 3-pin read" :
            "R6 read word", pat, w & m);
      end else begin
        chk((txCap & m) == (w & m), "R3 write shift", txCap & m, w & m);
      end
    end

    // R8 and R2: three-word frame
    regWrite(3'd1, 32'h0);
    regWrite(3'd0, cmdOf(0, 8, 4, 1));
    regWrite(3'd4, 32'h3C);
    armSlave(0, 32'h0, 2, 8, 128'h3C);
    for (int j = 0; j < 3; j++) begin
      regWrite(3'd0, cmdOf(0, 8, 2, 3));
      regRead(3'd2, v);
      chk(v == 32'd1, "R2 busy set, wc cleared", v, 1);
      waitIdle(cyc);
      if (j < 2) chk(csPin[0] == 1'b0, "R8 cs held between words", csPin, 4'hE);
      else chk(csPin[0] == 1'b1, "R8 cs released at frame end", csPin, 4'hF);
    end

    // R9: invalidate in mid-frame
    regWrite(3'd0, cmdOf(0, 8, 2, 4));
    waitIdle(cyc);
    chk(csPin[0] == 1'b0, "R9 frame open before invalidate", csPin, 4'hE);
    cyc = edges;
    regWrite(3'd0, cmdOf(0, 8, 4, 1));
    regRead(3'd2, v);
    chk(v == 0 && csPin == 4'hF, "R9 invalidate ends frame", {v, csPin}, 4'hF);
    repeat (4) @(negedge clk);
    chk(edges == cyc, "R9 no clock on invalidate", 128'(edges), 128'(cyc));

    // R10: writes while busy are ignored
    pat = 128'hF00D_CAFE_1357_9BDF_2468_ACE0_DEAD_0001;
    for (int k = 0; k < 4; k++) regWrite(3'(4 + k), pat[32*k +: 32]);
    armSlave(0, 32'h0, 2, 128, pat);
    regWrite(3'd0, cmdOf(0, 128, 2, 1));
    regWrite(3'd4, 32'h1111_2222);
    regWrite(3'd0, cmdOf(1, 8, 1, 1));
    waitIdle(cyc);
    chk(txCap == pat, "R10 data write ignored while busy", txCap, pat);
    regRead(3'd4, v);
    chk(v == pat[31:0], "R10 holding reg unchanged", v, pat[31:0]);
    repeat (3) @(negedge clk);
    regRead(3'd2, v);
    chk(v == 32'd2 && csPin == 4'hF, "R10 command ignored while busy", {v, csPin}, 128'h2F);
    regWrite(3'd0, cmdOf(1, 8, 0, 1));
    repeat (3) @(negedge clk);
    regRead(3'd2, v);
    chk(v == 32'd2 && csPin == 4'hF, "R10 op 0 ignored", {v, csPin}, 128'h2F);

    // R11: lane polarity readback and idle levels
    regWrite(3'd1, 32'hF802_0001);
    regRead(3'd1, v);
    chk(v == 32'hF802_0001, "R11 device control readback", v, 32'hF802_0001);
    regWrite(3'd0, cmdOf(0, 8, 4, 1));
    #1;
    chk(csPin == 4'b1011 && sclk == 1'b1, "R11 cs polarity and idle clock",
        {csPin, sclk}, {4'b1011, 1'b1});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule